// File: doc/BRIEF.md
# Byte-serial register load/store sequencer

This block moves data between the register file of a 24-bit machine and a memory port that carries one byte per transfer. A request names a transfer kind (full word, single character, or 48-bit floating value), a direction, a register, a start address and, for stores, the source value. The block then walks the needed bytes in rising address order. On a load it builds the register value and hands it to the register file in one write. On a store it splits the source value and sends it out one byte at a time.

The address is produced outside the block. The register file supplies the source value at request time. For a character load it also supplies the current contents of A, so that the upper part of A can be kept. A transfer of a full word takes three byte accesses, a floating transfer takes six, and a character transfer takes one. Each access lasts until the memory raises ready.

Top module: `ldst_aligner`

## Requirements
- R1: A word load (kind code 0) reads bytes m, m+1, m+2 and writes them to the register given by the select code (A=0, X=1, L=2, B=3, S=4, T=5). Byte m lands in bits 23:16 and byte m+2 in bits 7:0 of rf_data, and bits 47:24 are zero.
- R2: A floating load (kind code 2) reads bytes m..m+5 and writes them to select code 6 (F) whatever req_sel holds. Byte m goes into rf_data bits 47:40.
- R3: A character load (kind code 1) performs one read at m and writes to select code 0 (A). rf_data bits 7:0 hold the byte read, bits 23:8 hold req_data bits 23:8 as given with the request, and bits 47:24 are zero.
- R4: A word store writes req_data bits 23:16 to m, bits 15:8 to m+1 and bits 7:0 to m+2. Select codes 0 to 5 and the status word code 7 are accepted as sources.
- R5: A floating store writes req_data bits 47:40 to m, continuing down the value to bits 7:0 at m+5.
- R6: A character store performs exactly one write: req_data bits 7:0 to m. The bytes at m-1 and m+1 stay unchanged.
- R7: Accesses are made in rising address order, one byte for each cycle in which a strobe and mem_ready are both high. While mem_ready is low, the address, strobe and write data hold. Read and write strobes are never high together.
- R8: done is a one-cycle pulse in the cycle after the last byte is accepted. rf_we pulses with done for loads and stays low for stores.
- R9: busy rises in the cycle after a request is accepted and stays high until the last byte is accepted. A request made while busy is high is ignored.
- R10: These requests are ignored, with no access and no busy: kind code 3, a word load with select 6 or 7, and a word store with select 6.
- R11: During and right after reset, busy, done, rf_we, mem_rd and mem_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_kind | input | 2 | 0 word, 1 character, 2 floating |
| req_sel | input | 3 | Register select code |
| req_addr | input | ADDR_W | Start byte address m |
| req_data | input | FLT_W | Source value for stores; current A for character loads |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| mem_addr | output | ADDR_W | Byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | BYTE_W | Write byte |
| mem_rdata | input | BYTE_W | Read byte |
| mem_ready | input | 1 | Access accepted this cycle |
| rf_we | output | 1 | Register write enable |
| rf_sel | output | 3 | Register being written |
| rf_data | output | FLT_W | Register write value |

## Verification
The properties assume that the memory may hold mem_ready low for any number of cycles, and that mem_rdata is valid in any cycle where a read strobe meets ready. They also assume the requester may raise req_valid at any time, including during a transfer. The stimulus comes from a byte array model that answers in the same cycle. Its ready line follows a fixed stall pattern on alternate transfers and stays high on the others. Extra requests are raised on purpose while busy is high, and illegal kind and select codes are offered while the block is idle.

// File: rtl/ldst_aligner.sv
module ldst_aligner #(
  parameter int ADDR_W     = 16,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 3,
  parameter int FLT_BYTES  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_store,
  input  logic [1:0]                    req_kind,
  input  logic [2:0]                    req_sel,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [BYTE_W*FLT_BYTES-1:0]   req_data,
  output logic                          busy,
  output logic                          done,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_rd,
  output logic                          mem_wr,
  output logic [BYTE_W-1:0]             mem_wdata,
  input  logic [BYTE_W-1:0]             mem_rdata,
  input  logic                          mem_ready,
  output logic                          rf_we,
  output logic [2:0]                    rf_sel,
  output logic [BYTE_W*FLT_BYTES-1:0]   rf_data
);
  localparam int WORD_W = BYTE_W * WORD_BYTES;
  localparam int FLT_W  = BYTE_W * FLT_BYTES;
  localparam int CNT_W  = $clog2(FLT_BYTES);
  localparam logic [1:0] K_WORD = 2'd0;
  localparam logic [1:0] K_CHAR = 2'd1;
  localparam logic [1:0] K_FLT  = 2'd2;
  localparam logic [2:0] SEL_A  = 3'd0;
  localparam logic [2:0] SEL_F  = 3'd6;
  localparam logic [2:0] SEL_SW = 3'd7;

  logic              st_q;
  logic [1:0]        kind_q;
  logic [2:0]        sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [FLT_W-1:0]  sh_q;
  logic [WORD_W-BYTE_W-1:0] keep_q;

  logic legal, start, step, last;

  assign legal = (req_kind == K_FLT) || (req_kind == K_CHAR) ||
                 ((req_kind == K_WORD) && (req_sel != SEL_F) &&
                  (req_store || (req_sel != SEL_SW)));
  assign start = req_valid && !busy && legal;
  assign step  = busy && mem_ready;
  assign last  = step && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      st_q   <= 1'b0;
      kind_q <= K_WORD;
      sel_q  <= SEL_A;
      addr_q <= '0;
      left_q <= '0;
      sh_q   <= '0;
      keep_q <= '0;
    end else begin
      done <= last;
      if (start) begin
        busy   <= 1'b1;
        st_q   <= req_store;
        kind_q <= req_kind;
        addr_q <= req_addr;
        keep_q <= req_data[WORD_W-1:BYTE_W];
        unique case (req_kind)
          K_FLT: begin
            sel_q  <= SEL_F;
            left_q <= CNT_W'(FLT_BYTES - 1);
            sh_q   <= req_data;
          end
          K_CHAR: begin
            sel_q  <= SEL_A;
            left_q <= '0;
            sh_q   <= {req_data[BYTE_W-1:0], {(FLT_W-BYTE_W){1'b0}}};
          end
          default: begin
            sel_q  <= req_sel;
            left_q <= CNT_W'(WORD_BYTES - 1);
            sh_q   <= {req_data[WORD_W-1:0], {(FLT_W-WORD_W){1'b0}}};
          end
        endcase
      end else if (step) begin
        sh_q   <= {sh_q[FLT_W-BYTE_W-1:0], mem_rdata};
        addr_q <= addr_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_rd    = busy && !st_q;
  assign mem_wr    = busy && st_q;
  assign mem_wdata = sh_q[FLT_W-1 -: BYTE_W];
  assign rf_we     = done && !st_q;
  assign rf_sel    = sel_q;

  always_comb begin
    rf_data = '0;
    if (rf_we) begin
      unique case (kind_q)
        K_FLT:   rf_data = sh_q;
        K_CHAR:  rf_data[WORD_W-1:0] = {keep_q, sh_q[BYTE_W-1:0]};
        default: rf_data[WORD_W-1:0] = sh_q[WORD_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ldst_aligner_chk.sv
module ldst_aligner_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              rf_we
);
  // R7
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R9
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  // R9
  busy_drives_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_rd || mem_wr));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata) &&
                              $stable(mem_rd) && $stable(mem_wr)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ready) |=> (!busy || (mem_addr == $past(mem_addr) + 1'b1)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R8
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);
endmodule

bind ldst_aligner ldst_aligner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .rf_we(rf_we)
);

// File: tb/test_ldst_aligner.sv
module test_ldst_aligner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [1:0] req_kind = '0;
  logic [2:0] req_sel = '0;
  logic [15:0] req_addr = '0;
  logic [47:0] req_data = '0;
  logic busy, done, mem_rd, mem_wr, mem_ready, rf_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [2:0] rf_sel;
  logic [47:0] rf_data;

  always #5 clk = ~clk;

  ldst_aligner i_ldst_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_kind(req_kind), .req_sel(req_sel), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_we(rf_we),
    .rf_sel(rf_sel), .rf_data(rf_data)
  );

  logic [7:0] mem [256];
  logic stall = 1'b0;
  int unsigned cyc = 0;
  int acc_n = 0;
  logic [15:0] acc_addr [1024];
  int checks = 0, fails = 0;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = !stall || (cyc % 3 != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 11);
    end else begin
      if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
      if ((mem_rd || mem_wr) && mem_ready) begin
        acc_addr[acc_n % 1024] <= mem_addr;
        acc_n <= acc_n + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic st, input logic [1:0] k, input logic [2:0] s,
                      input logic [15:0] a, input logic [47:0] d);
    int nb, base, w;
    logic [47:0] exp, got;
    logic [7:0] lo, hi;
    logic ord;
    string tag;
    nb = (k == 2'd2) ? 6 : (k == 2'd1) ? 1 : 3;
    tag = (k == 2'd2) ? (st ? "R5" : "R2") : (k == 2'd1) ? (st ? "R6" : "R3") : (st ? "R4" : "R1");
    exp = '0;
    for (int i = 0; i < nb; i++) exp = {exp[39:0], mem[8'(a + 16'(i))]};
    if (k == 2'd1 && !st) exp = {24'b0, d[23:8], mem[a[7:0]]};
    if (k == 2'd0 && !st) exp[47:24] = '0;
    lo = mem[8'(a - 16'd1)];
    hi = mem[8'(a + 16'(nb))];
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_kind = k; req_sel = s;
    req_addr = a; req_data = d; base = acc_n;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    w = 0;
    while (done !== 1'b1 && w < 200) begin @(negedge clk); w++; end
    chk(done === 1'b1, "R8 done seen", 64'(done), 64'd1);
    chk(rf_we === !st, "R8 rf_we only on load", 64'(rf_we), 64'(!st));
    chk(acc_n - base == nb, {tag, " R7 access count"}, 64'(acc_n - base), 64'(nb));
    ord = 1'b1;
    for (int i = 0; i < nb; i++) if (acc_addr[(base + i) % 1024] !== a + 16'(i)) ord = 1'b0;
    chk(ord, {tag, " R7 ascending addresses"}, 64'(ord), 64'd1);
    if (!st) begin
      chk(rf_sel === ((k == 2'd2) ? 3'd6 : (k == 2'd1) ? 3'd0 : s), {tag, " rf_sel"}, 64'(rf_sel), 64'(s));
      chk(rf_data === exp, {tag, " rf_data"}, 64'(rf_data), 64'(exp));
    end else begin
      got = '0;
      for (int i = 0; i < nb; i++) got = {got[39:0], mem[8'(a + 16'(i))]};
      exp = (k == 2'd2) ? d : (k == 2'd1) ? {40'b0, d[7:0]} : {24'b0, d[23:0]};
      chk(got === exp, {tag, " memory bytes"}, 64'(got), 64'(exp));
      chk(mem[8'(a - 16'd1)] === lo && mem[8'(a + 16'(nb))] === hi, {tag, " neighbours kept"},
          64'({mem[8'(a - 16'd1)], mem[8'(a + 16'(nb))]}), 64'({lo, hi}));
    end
    @(negedge clk);
  endtask

  localparam logic [63:0] VEC [8] = '{
    {1'b0, 2'd0, 3'd1, 10'd10,  48'h0},
    {1'b0, 2'd0, 3'd5, 10'd254, 48'h0},
    {1'b0, 2'd2, 3'd3, 10'd40,  48'h0},
    {1'b0, 2'd1, 3'd4, 10'd77,  48'h0000_00AB_CDEF},
    {1'b1, 2'd0, 3'd7, 10'd100, 48'h0000_0012_3456},
    {1'b1, 2'd2, 3'd0, 10'd120, 48'hA1B2_C3D4_E5F6},
    {1'b1, 2'd1, 3'd0, 10'd150, 48'h0000_0099_8877},
    {1'b0, 2'd0, 3'd0, 10'd100, 48'h0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !done && !rf_we && !mem_rd && !mem_wr, "R11 reset outputs",
        64'({busy, done, rf_we, mem_rd, mem_wr}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_rd && !mem_wr, "R11 idle after reset", 64'({busy, mem_rd, mem_wr}), 64'd0);

    for (int v = 0; v < 8; v++) begin
      stall = v[0];
      xfer(VEC[v][63], VEC[v][62:61], VEC[v][60:58], {6'b0, VEC[v][57:48]}, VEC[v][47:0]);
    end

    // R9: request during busy is ignored
    begin
      int base, w;
      stall = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_kind = 2'd0; req_sel = 3'd2; req_addr = 16'd60;
      base = acc_n;
      @(negedge clk);
      req_kind = 2'd2; req_addr = 16'd200;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      w = 0;
      while (done !== 1'b1 && w < 200) begin @(negedge clk); w++; end
      chk(rf_data === {24'b0, mem[60], mem[61], mem[62]}, "R9 first request data",
          64'(rf_data), 64'({24'b0, mem[60], mem[61], mem[62]}));
      repeat (8) @(negedge clk);
      chk(acc_n - base == 3 && !busy, "R9 busy request ignored", 64'(acc_n - base), 64'd3);
    end

    // R10: illegal codes
    begin
      int base;
      stall = 1'b0;
      base = acc_n;
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_kind = 2'd3; req_sel = 3'd0; req_addr = 16'd5;
      @(negedge clk);
      chk(!busy, "R10 kind 3", 64'(busy), 64'd0);
      req_kind = 2'd0; req_sel = 3'd6;
      @(negedge clk);
      chk(!busy, "R10 word load F", 64'(busy), 64'd0);
      req_sel = 3'd7;
      @(negedge clk);
      chk(!busy, "R10 word load SW", 64'(busy), 64'd0);
      req_store = 1'b1; req_sel = 3'd6;
      @(negedge clk);
      chk(!busy, "R10 word store F", 64'(busy), 64'd0);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(acc_n == base && !done, "R10 no access", 64'(acc_n - base), 64'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule